// File: doc/BRIEF.md
# Prioritised Interrupt Controller Bank

This block collects up to 32 interrupt request lines and presents them to a processor as two requests: a normal request and a fast request. Software reaches the block over a simple register bus (one write strobe, an address, write data and a combinational read data path). Each line has its own configuration word. The word says whether the line is sampled as a level or caught on a rising edge, whether it goes to the fast or the normal request, and what its priority is. A mask word disables individual lines, and a single global mask bit silences both requests at once.

For each class (normal and fast), the pending and unmasked lines of that class compete. The lowest priority value wins, and a tie goes to the lowest line number. Once a request is raised, the winning line number and the request stay frozen until software acknowledges that class through the control register. On the clock after the acknowledge, the block arbitrates again. A bank built with `PRIMARY = 0` is meant to serve as a second-level controller whose normal request drives a line of a primary bank. In such a bank the fast-steering bit does not exist and every line is a normal request. Software acknowledges the second-level bank first and the primary bank second.

Top module: `intc_bank`

## Requirements
- R1: After reset the mask word (offset 0x00) reads all ones, the pending word (offset 0x04) reads zero, every line configuration word reads zero (rising-edge mode, priority 0, normal class), the global mask (offset 0x0C bit 0) is 0, and both requests are low.
- R2: A 1 in bit i of the mask word stops line i from being chosen, so no request is raised for it. Its pending bit can still be read in the pending word.
- R3: The configuration word of line i sits at offset 0x80 + 4*i. Bit 0 steers the line to the fast request, bit 1 selects level mode (1) or rising-edge mode (0), and bits 6:2 hold the priority. Every written field reads back unchanged.
- R4: In rising-edge mode, a 0-to-1 transition on the input sets a pending bit that stays set after the input falls. In level mode, the pending bit follows the input directly and nothing is stored.
- R5: Within one class, the candidate with the lowest priority value wins. Among equal priority values, the lowest line number wins.
- R6: From the clock on which a request rises until that class is acknowledged, the request stays high and its reported line number does not change, even if a better candidate becomes pending.
- R7: Writing the control word (offset 0x08) with bit 0 set acknowledges the normal request, and with bit 1 set acknowledges the fast request; 0x3 acknowledges both. An acknowledged request falls on that same clock. In rising-edge mode the acknowledged line's pending bit is cleared. On the following clock the next winner, if there is one, is captured.
- R8: In a bank with PRIMARY=1, a line whose bit 0 is set is served on the fast request only. In a bank with PRIMARY=0, bit 0 reads as 0, the fast request never rises, and such a line is served on the normal request.
- R9: A write to the pending word clears each stored edge bit whose write-data bit is 0. Writing 0 therefore clears all of them.
- R10: While the global mask bit is 1, both requests are low and no new winner is captured. Once it returns to 0, a pending winner is taken up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data (combinational) |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |
| irq_line | output | $clog2(NUM_LINES) | Winning line of the normal request, 0 when idle |
| fiq_line | output | $clog2(NUM_LINES) | Winning line of the fast request, 0 when idle |

## Verification
Some properties are checked on every cycle. The line number and request stay frozen while no acknowledge arrives, and an acknowledge drops the request on the next clock. A captured winner was a real unmasked candidate of its class. Stored edge bits survive until they are cleared, and the global mask keeps both requests quiet. A non-primary bank never raises the fast request. The order of winners across priorities and ties, the difference between level and edge lines after an acknowledge, the read-back of configuration words and the pending-clear write can only be shown by the bench's scenarios, which a behavioural model compares with the outputs on every clock.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam logic [7:0] OFS_MASK     = 8'h00;
   localparam logic [7:0] OFS_PEND     = 8'h04;
   localparam logic [7:0] OFS_CTRL     = 8'h08;
   localparam logic [7:0] OFS_GMASK    = 8'h0C;
   localparam logic [7:0] OFS_LVL_BASE = 8'h80;
   localparam int         CLS_N        = 2;   // 0 = normal, 1 = fast
   localparam int         LVL_FIQ_BIT  = 0;
   localparam int         LVL_TRIG_BIT = 1;
   localparam int         LVL_PRIO_LSB = 2;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int PRIO_W    = 5,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter bit PRIMARY   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_LINES-1:0]  pend_i,
   output logic [NUM_LINES-1:0]  mask_o,
   output logic                  gmask_o,
   output logic [NUM_LINES-1:0]  fiq_sel_o,
   output logic [NUM_LINES-1:0]  trig_o,
   output logic [NUM_LINES-1:0][PRIO_W-1:0] prio_o,
   output logic [CLS_N-1:0]      ack_o,
   output logic                  pend_wr_o,
   output logic [NUM_LINES-1:0]  pend_keep_o
);
   localparam int PAD_W = DATA_W - PRIO_W - 2;

   logic [ADDR_W-1:0]    lvl_off;
   logic                 lvl_hit;
   logic [NUM_LINES-1:0] lvl_sel;
   logic [NUM_LINES-1:0] mask_q;
   logic                 gmask_q;

   assign lvl_hit = bus_addr >= ADDR_W'(OFS_LVL_BASE);
   assign lvl_off = bus_addr - ADDR_W'(OFS_LVL_BASE);

   always_comb begin
      for (int i = 0; i < NUM_LINES; i++)
         lvl_sel[i] = lvl_hit && (lvl_off == ADDR_W'(4 * i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         gmask_q <= 1'b0;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_W'(OFS_MASK))  mask_q  <= bus_wdata[NUM_LINES-1:0];
         if (bus_addr == ADDR_W'(OFS_GMASK)) gmask_q <= bus_wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_o <= '0;
         prio_o <= '0;
      end else begin
         for (int i = 0; i < NUM_LINES; i++) begin
            if (bus_wr && lvl_sel[i]) begin
               trig_o[i] <= bus_wdata[LVL_TRIG_BIT];
               prio_o[i] <= bus_wdata[LVL_PRIO_LSB +: PRIO_W];
            end
         end
      end
   end

   generate
      if (PRIMARY) begin : g_fiq
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fiq_sel_o <= '0;
            else begin
               for (int i = 0; i < NUM_LINES; i++)
                  if (bus_wr && lvl_sel[i]) fiq_sel_o[i] <= bus_wdata[LVL_FIQ_BIT];
            end
         end
      end else begin : g_nofiq
         assign fiq_sel_o = '0;
      end
   endgenerate

   assign mask_o      = mask_q;
   assign gmask_o     = gmask_q;
   assign ack_o[0]    = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[0];
   assign ack_o[1]    = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[1];
   assign pend_wr_o   = bus_wr && (bus_addr == ADDR_W'(OFS_PEND));
   assign pend_keep_o = bus_wdata[NUM_LINES-1:0];

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_MASK))  bus_rdata[NUM_LINES-1:0] = mask_q;
      if (bus_addr == ADDR_W'(OFS_PEND))  bus_rdata[NUM_LINES-1:0] = pend_i;
      if (bus_addr == ADDR_W'(OFS_GMASK)) bus_rdata[0] = gmask_q;
      for (int i = 0; i < NUM_LINES; i++)
         if (lvl_sel[i])
            bus_rdata = {{PAD_W{1'b0}}, prio_o[i], trig_o[i], fiq_sel_o[i]};
   end

   generate
      if (!PRIMARY) begin : g_chk_nofiq
         AST_NO_FIQ_STEER: assert property (@(posedge clk) disable iff (!rst_n)
            fiq_sel_o == '0); // R8
      end
   endgenerate
endmodule

// File: rtl/intc_pend.sv
module intc_pend #(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic [NUM_LINES-1:0] trig,
   input  logic [NUM_LINES-1:0] clr_ack,
   input  logic                 wr_clr,
   input  logic [NUM_LINES-1:0] wr_keep,
   output logic [NUM_LINES-1:0] pend_o
);
   logic [NUM_LINES-1:0] prev_q, latch_q, rise, set_v, wclr;

   assign rise  = irq_in & ~prev_q;
   assign set_v = rise & ~trig;
   assign wclr  = wr_clr ? ~wr_keep : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         latch_q <= '0;
      end else begin
         prev_q  <= irq_in;
         latch_q <= (latch_q & ~clr_ack & ~wclr) | set_v;
      end
   end

   assign pend_o = (latch_q & ~trig) | (irq_in & trig);

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v != '0) |=> ((latch_q & $past(set_v)) == $past(set_v))); // R4
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_ack & ~set_v) != '0) |=> ((latch_q & $past(clr_ack & ~set_v)) == '0)); // R7
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
   parameter int NUM_LINES = 32,
   parameter int PRIO_W    = 5
) (
   input  logic [NUM_LINES-1:0]             cand,
   input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
   output logic                             any,
   output logic [$clog2(NUM_LINES)-1:0]     win
);
   localparam int IDX_W = $clog2(NUM_LINES);
   logic [PRIO_W-1:0] best_p;

   always_comb begin
      any    = 1'b0;
      best_p = '0;
      win    = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (cand[i] && (!any || prio[i] < best_p)) begin
            any    = 1'b1;
            best_p = prio[i];
            win    = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/intc_hold.sv
module intc_hold #(
   parameter int NUM_LINES = 32,
   parameter int PRIO_W    = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_LINES-1:0]             cand,
   input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
   input  logic                             gmask,
   input  logic                             ack,
   output logic                             req_o,
   output logic [$clog2(NUM_LINES)-1:0]     line_o,
   output logic [NUM_LINES-1:0]             clr_o
);
   localparam int IDX_W = $clog2(NUM_LINES);

   logic             any;
   logic [IDX_W-1:0] win, line_q;
   logic             active_q;

   intc_arb #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_arb (
      .cand (cand),
      .prio (prio),
      .any  (any),
      .win  (win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         line_q   <= '0;
      end else if (active_q && ack) begin
         active_q <= 1'b0;
      end else if (!active_q && any && !gmask) begin
         active_q <= 1'b1;
         line_q   <= win;
      end
   end

   always_comb begin
      clr_o = '0;
      if (active_q && ack) clr_o[line_q] = 1'b1;
   end

   assign req_o  = active_q && !gmask;
   assign line_o = active_q ? line_q : '0;

   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !ack) |=> (active_q && $stable(line_q))); // R6
   AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && ack) |=> !active_q); // R7
   AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && any && !gmask) |=> (active_q && $past(cand[win]))); // R2
   AST_GMASK_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && gmask) |=> !active_q); // R10
endmodule

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int PRIO_W    = 5,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter bit PRIMARY   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_LINES-1:0]         irq_in,
   input  logic                         bus_wr,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   output logic                         irq_out,
   output logic                         fiq_out,
   output logic [$clog2(NUM_LINES)-1:0] irq_line,
   output logic [$clog2(NUM_LINES)-1:0] fiq_line
);
   localparam int IDX_W = $clog2(NUM_LINES);

   generate
      if (NUM_LINES < 2 || NUM_LINES > 32) begin : g_bad_lines
         $error("NUM_LINES must lie in 2..32");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("DATA_W must be 32");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be at least 8");
      end
      if (PRIO_W < 1 || PRIO_W > 5) begin : g_bad_prio
         $error("PRIO_W must lie in 1..5");
      end
   endgenerate

   logic [NUM_LINES-1:0]             pend, mask, fiq_sel, trig, pend_keep, clr_all;
   logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
   logic                             gmask, pend_wr;
   logic [CLS_N-1:0]                 ack, req;
   logic [CLS_N-1:0][IDX_W-1:0]      line;
   logic [CLS_N-1:0][NUM_LINES-1:0]  clr, cand;

   intc_regs #(
      .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .PRIMARY(PRIMARY)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .pend_i      (pend),
      .mask_o      (mask),
      .gmask_o     (gmask),
      .fiq_sel_o   (fiq_sel),
      .trig_o      (trig),
      .prio_o      (prio),
      .ack_o       (ack),
      .pend_wr_o   (pend_wr),
      .pend_keep_o (pend_keep)
   );

   intc_pend #(.NUM_LINES(NUM_LINES)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_in  (irq_in),
      .trig    (trig),
      .clr_ack (clr_all),
      .wr_clr  (pend_wr),
      .wr_keep (pend_keep),
      .pend_o  (pend)
   );

   generate
      for (genvar c = 0; c < CLS_N; c++) begin : g_cls
         if (c == 1) begin : g_fast
            assign cand[c] = pend & ~mask & fiq_sel;
         end else begin : g_norm
            assign cand[c] = pend & ~mask & ~fiq_sel;
         end
         intc_hold #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .cand   (cand[c]),
            .prio   (prio),
            .gmask  (gmask),
            .ack    (ack[c]),
            .req_o  (req[c]),
            .line_o (line[c]),
            .clr_o  (clr[c])
         );
      end
   endgenerate

   assign clr_all  = clr[0] | clr[1];
   assign irq_out  = req[0];
   assign fiq_out  = req[1];
   assign irq_line = line[0];
   assign fiq_line = line[1];

   AST_GMASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      gmask |-> (!irq_out && !fiq_out)); // R10

   generate
      if (!PRIMARY) begin : g_chk_fast
         AST_NO_FAST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            !fiq_out); // R8
      end
   endgenerate
endmodule

// File: tb/sim_intc_bank.sv
module sim_intc_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out, fiq_out;
   logic [4:0]  irq_line, fiq_line;

   logic [31:0] in1 = '0;
   logic        b1_wr = 1'b0;
   logic [7:0]  b1_addr = '0;
   logic [31:0] b1_wdata = '0;
   logic [31:0] b1_rdata;
   logic        irq1, fiq1;
   logic [4:0]  irq1_line, fiq1_line;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   intc_bank #(.PRIMARY(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out), .fiq_out(fiq_out), .irq_line(irq_line), .fiq_line(fiq_line)
   );

   intc_bank #(.PRIMARY(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .irq_in(in1), .bus_wr(b1_wr),
      .bus_addr(b1_addr), .bus_wdata(b1_wdata), .bus_rdata(b1_rdata),
      .irq_out(irq1), .fiq_out(fiq1), .irq_line(irq1_line), .fiq_line(fiq1_line)
   );

   // ---------------- behavioural reference model of u0 ----------------
   logic [31:0] m_mask, m_latch, m_prev;
   bit          m_gm;
   int          m_prio [32];
   bit          m_trig [32];
   bit          m_fiq  [32];
   bit          m_act  [2];
   int          m_hl   [2];

   function automatic int pick(input logic [31:0] c);
      int best = -1;
      for (int i = 0; i < 32; i++)
         if (c[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
      return best;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mask = '1; m_latch = '0; m_prev = '0; m_gm = 1'b0;
         for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_trig[i] = 0; m_fiq[i] = 0; end
         for (int c = 0; c < 2; c++) begin m_act[c] = 0; m_hl[c] = 0; end
      end else begin
         logic [31:0] tv, fv, pv, clr, wclr, rise;
         bit ack [2];
         tv = '0; fv = '0;
         for (int i = 0; i < 32; i++) begin tv[i] = m_trig[i]; fv[i] = m_fiq[i]; end
         pv = (m_latch & ~tv) | (irq_in & tv);
         ack[0] = bus_wr && bus_addr == 8'h08 && bus_wdata[0];
         ack[1] = bus_wr && bus_addr == 8'h08 && bus_wdata[1];
         clr = '0;
         for (int c = 0; c < 2; c++) begin
            if (m_act[c] && ack[c]) begin
               m_act[c] = 0;
               clr[m_hl[c]] = 1'b1;
            end else if (!m_act[c] && !m_gm) begin
               int w;
               w = pick(pv & ~m_mask & (c == 1 ? fv : ~fv));
               if (w >= 0) begin m_act[c] = 1; m_hl[c] = w; end
            end
         end
         rise = irq_in & ~m_prev;
         wclr = (bus_wr && bus_addr == 8'h04) ? ~bus_wdata : '0;
         m_latch = (m_latch & ~clr & ~wclr) | (rise & ~tv);
         m_prev = irq_in;
         if (bus_wr) begin
            if (bus_addr == 8'h00) m_mask = bus_wdata;
            if (bus_addr == 8'h0C) m_gm = bus_wdata[0];
            if (bus_addr >= 8'h80 && bus_addr[1:0] == 2'b00) begin
               int k;
               k = (int'(bus_addr) - 128) / 4;
               m_fiq[k]  = bus_wdata[0];
               m_trig[k] = bus_wdata[1];
               m_prio[k] = int'(bus_wdata[6:2]);
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e_irq, e_fiq;
         logic [4:0] e_il, e_fl;
         e_irq = m_act[0] && !m_gm;
         e_fiq = m_act[1] && !m_gm;
         e_il  = m_act[0] ? 5'(m_hl[0]) : 5'd0;
         e_fl  = m_act[1] ? 5'(m_hl[1]) : 5'd0;
         n_cmp++;
         if ({irq_out, fiq_out, irq_line, fiq_line} !== {e_irq, e_fiq, e_il, e_fl}) begin
            n_bad++;
            $display("FAIL R5 model compare at %0t: got irq=%0d fiq=%0d il=%0d fl=%0d exp irq=%0d fiq=%0d il=%0d fl=%0d",
                     $time, irq_out, fiq_out, irq_line, fiq_line, e_irq, e_fiq, e_il, e_fl);
         end
      end
   end

   // ---------------- tasks ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse(input logic [31:0] v);
      @(negedge clk); irq_in = irq_in | v;
      @(negedge clk); irq_in = irq_in & ~v;
   endtask

   task automatic wr1(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); b1_wr = 1'b1; b1_addr = a; b1_wdata = d;
      @(negedge clk); b1_wr = 1'b0; b1_wdata = '0;
   endtask

   task automatic summary();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      logic [31:0] d;
      idle(3);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, d); chk("R1 mask reset", d, 32'hFFFF_FFFF);
      rd(8'h04, d); chk("R1 pending reset", d, 32'h0);
      rd(8'h80, d); chk("R1 level reset", d, 32'h0);
      rd(8'h0C, d); chk("R1 gmask reset", d, 32'h0);
      chk("R1 requests low", {30'd0, irq_out, fiq_out}, 32'h0);

      // R3 configuration word layout
      wr(8'h80 + 8'd20, 32'h0000_000E);       // line 5: level, prio 3
      rd(8'h80 + 8'd20, d); chk("R3 level readback", d, 32'h0000_000E);
      wr(8'h80 + 8'd36, 32'h0000_0001);       // line 9: fast, edge, prio 0
      rd(8'h80 + 8'd36, d); chk("R3 fast readback", d, 32'h0000_0001);
      wr(8'h00, 32'h0);

      // R4 edge latch
      pulse(32'h1 << 7);
      idle(3);
      chk("R4 edge request", {26'd0, irq_out, irq_line}, {26'd0, 1'b1, 5'd7});
      rd(8'h04, d); chk("R4 sticky pending", d & (32'h1 << 7), 32'h1 << 7);

      // R6 freeze while a better-tied line arrives
      pulse(32'h1 << 1);
      idle(3);
      chk("R6 frozen line", {27'd0, irq_line}, 32'd7);

      // R7 acknowledge and re-arbitration
      wr(8'h08, 32'h1);
      chk("R7 request drops", {31'd0, irq_out}, 32'd0);
      idle(1);
      chk("R7 next winner", {26'd0, irq_out, irq_line}, {26'd0, 1'b1, 5'd1});
      wr(8'h08, 32'h1); idle(2);

      // R5 ties and priority order
      wr(8'h80 + 8'd40, 32'h10);               // line 10 prio 4
      wr(8'h80 + 8'd48, 32'h10);               // line 12 prio 4
      pulse((32'h1 << 10) | (32'h1 << 12));
      idle(3);
      chk("R5 tie lowest line", {27'd0, irq_line}, 32'd10);
      wr(8'h08, 32'h1); idle(2);
      chk("R5 tie second", {27'd0, irq_line}, 32'd12);
      wr(8'h08, 32'h1); idle(2);
      wr(8'h80 + 8'd80, 32'h04);               // line 20 prio 1
      wr(8'h80 + 8'd12, 32'h24);               // line 3 prio 9
      pulse((32'h1 << 20) | (32'h1 << 3));
      idle(3);
      chk("R5 lowest value wins", {27'd0, irq_line}, 32'd20);
      wr(8'h08, 32'h1); idle(2);
      chk("R5 then line 3", {27'd0, irq_line}, 32'd3);
      wr(8'h08, 32'h1); idle(2);

      // R4 level mode follows input, nothing stored
      @(negedge clk); irq_in[5] = 1'b1;
      idle(2);
      chk("R4 level request", {26'd0, irq_out, irq_line}, {26'd0, 1'b1, 5'd5});
      @(negedge clk); irq_in[5] = 1'b0;
      wr(8'h08, 32'h1); idle(3);
      chk("R4 level not stored", {31'd0, irq_out}, 32'd0);
      rd(8'h04, d); chk("R4 level pending gone", d, 32'h0);

      // R8 fast steering
      pulse((32'h1 << 9) | (32'h1 << 7));
      idle(3);
      chk("R8 fast line", {26'd0, fiq_out, fiq_line}, {26'd0, 1'b1, 5'd9});
      chk("R8 normal line", {26'd0, irq_out, irq_line}, {26'd0, 1'b1, 5'd7});
      wr(8'h08, 32'h3);
      chk("R7 both acked", {30'd0, irq_out, fiq_out}, 32'd0);
      idle(2);

      // R2 mask
      wr(8'h00, 32'h1 << 15);
      pulse(32'h1 << 15);
      idle(4);
      chk("R2 masked no request", {31'd0, irq_out}, 32'd0);
      rd(8'h04, d); chk("R2 pending visible", d, 32'h1 << 15);

      // R9 pending clear
      wr(8'h04, 32'h0);
      rd(8'h04, d); chk("R9 pending cleared", d, 32'h0);
      wr(8'h00, 32'h0);
      idle(3);
      chk("R9 nothing after unmask", {31'd0, irq_out}, 32'd0);

      // R10 global mask
      wr(8'h0C, 32'h1);
      pulse(32'h1 << 7);
      idle(4);
      chk("R10 gmask quiet", {30'd0, irq_out, fiq_out}, 32'd0);
      wr(8'h0C, 32'h0);
      idle(3);
      chk("R10 taken after release", {26'd0, irq_out, irq_line}, {26'd0, 1'b1, 5'd7});
      wr(8'h08, 32'h1); idle(2);

      // R8 non-primary bank
      wr1(8'h00, 32'h0);
      wr1(8'h80 + 8'd16, 32'h1);               // line 4, fast bit requested
      @(negedge clk); b1_addr = 8'h80 + 8'd16; #1 d = b1_rdata;
      chk("R8 non-primary bit0 reads 0", d, 32'h0);
      @(negedge clk); in1[4] = 1'b1;
      @(negedge clk); in1[4] = 1'b0;
      idle(3);
      chk("R8 non-primary no fast", {31'd0, fiq1}, 32'd0);
      chk("R8 non-primary normal", {26'd0, irq1, irq1_line}, {26'd0, 1'b1, 5'd4});

      idle(2);
      summary();
   end
endmodule